// File: doc/BRIEF.md
# Bidirectional GPIO Port with LCD Data-Bus Sharing

This block is an eight-line general-purpose I/O port that sits on a simple byte-wide register bus. Software sets each line's direction and its output level. It can also give any line, one at a time, to an LCD controller. When a line is given to the LCD controller, that controller's data bus decides the line's drive enable and drive level. The block decodes three bus addresses, holds the output latch, the direction bits and the function-select bits, and forms the per-pin output enable and output value for the pad cells. It also returns the port state on a registered read path.

External pin levels pass through a small synchronizer before any read uses them. The same synchronized levels go back to the LCD controller as its input data. The direction and function-select registers cannot be read back: a read of their addresses returns zero. Software must therefore keep its own copy of those registers. The output latch comes out of reset at all ones, so a line switched to output before any data write drives high.

Top module: `gpio_lcd_port`

## Requirements
- R1: After a synchronous active-high reset, the direction bits and function bits are 0 and every output-latch bit is 1. As a result, pin_oe is all zeros, pin_out is all ones and bus_rdata is 0.
- R2: A write with bus_we high to the data address (BASE_ADDR+0) loads bus_wdata into the output latch at that clock edge. This happens even for lines that are configured as inputs.
- R3: For a line whose function bit is 0, pin_oe[n] equals direction bit n (0 = input, 1 = output) and pin_out[n] equals latch bit n. A write to the direction address (BASE_ADDR+1) loads all direction bits at that edge.
- R4: For a line whose function bit is 1, pin_oe[n] follows lcd_doe[n] and pin_out[n] follows lcd_dout[n]. That line's direction and latch bits have no effect. A write to the function address (BASE_ADDR+2) loads all function bits at that edge.
- R5: A read of the data address returns, for each line, latch bit n when the line is a port output (function 0, direction 1). In every other case it returns the synchronized pin level.
- R6: A read of the direction or function address returns 0 and changes no register or output.
- R7: Writes to any address outside BASE_ADDR..BASE_ADDR+2 change no register and no output. Reads of those addresses return 0.
- R8: bus_rdata is loaded at the edge where bus_re is high, using the state before any write at that same edge. It holds its value while bus_re is low.
- R9: Pin levels reach lcd_din and the read path through SYNC_STAGES flip-flops. A read issued at the first edge after a pin change still returns the old level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | WIDTH | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Level seen on each external pin |
| pin_out | output | WIDTH | Value driven onto each pin |
| pin_oe | output | WIDTH | Per-pin output enable, 1 = drive |
| lcd_dout | input | WIDTH | Data from the LCD controller |
| lcd_doe | input | WIDTH | Per-line drive enable from the LCD controller |
| lcd_din | output | WIDTH | Synchronized pin levels for the LCD controller |

## Verification
The bench builds the block with its defaults: eight lines, an eight-bit address, base address 0x2C and a two-stage synchronizer. With these values every line takes part in mixed direction and function patterns. The addresses just below and just above the register window (0x2B and 0x2F) can be tested for being ignored. The two-flop latency is short enough to check exactly: the stale value at the first edge after a pin change, then the fresh value after the second edge.

// File: rtl/gpio_lcd_pkg.sv
package gpio_lcd_pkg;

  // Which register a bus address selects
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_FUNC = 2'd3
  } reg_sel_e;

  // Byte offsets of the registers from the base address
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_DIR  = 1;
  localparam int unsigned OFS_FUNC = 2;

endpackage

// File: rtl/gpio_lcd_regs.sv
module gpio_lcd_regs
  import gpio_lcd_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 32'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              we,
  output reg_sel_e          sel,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  func_q
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE_ADDR + OFS_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(BASE_ADDR + OFS_DIR);
  localparam logic [ADDR_W-1:0] A_FUNC = ADDR_W'(BASE_ADDR + OFS_FUNC);

  always_comb begin
    if (addr == A_DATA)      sel = SEL_DATA;
    else if (addr == A_DIR)  sel = SEL_DIR;
    else if (addr == A_FUNC) sel = SEL_FUNC;
    else                     sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      dir_q   <= '0;
      func_q  <= '0;
    end else if (we) begin
      case (sel)
        SEL_DATA: latch_q <= wdata;
        SEL_DIR:  dir_q   <= wdata;
        SEL_FUNC: func_q  <= wdata;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_lcd_insync.sv
module gpio_lcd_insync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio_lcd_padmux.sv
module gpio_lcd_padmux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] func_q,
  input  logic [WIDTH-1:0] lcd_dout,
  input  logic [WIDTH-1:0] lcd_doe,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] rd_view
);

  genvar n;
  generate
    for (n = 0; n < WIDTH; n++) begin : g_bit
      logic gpio_drive;
      assign gpio_drive = ~func_q[n] & dir_q[n];
      assign pin_oe[n]  = func_q[n] ? lcd_doe[n]  : dir_q[n];
      assign pin_out[n] = func_q[n] ? lcd_dout[n] : latch_q[n];
      assign rd_view[n] = gpio_drive ? latch_q[n] : pin_sync[n];
    end
  endgenerate

endmodule

// File: rtl/gpio_lcd_port.sv
module gpio_lcd_port
  import gpio_lcd_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BASE_ADDR   = 32'h2C,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic [WIDTH-1:0]  lcd_dout,
  input  logic [WIDTH-1:0]  lcd_doe,
  output logic [WIDTH-1:0]  lcd_din
);

  reg_sel_e         sel;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] func_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] rd_view;

  gpio_lcd_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .sel(sel), .latch_q(latch_q), .dir_q(dir_q), .func_q(func_q)
  );

  gpio_lcd_insync #(
    .WIDTH(WIDTH), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(pin_sync)
  );

  gpio_lcd_padmux #(
    .WIDTH(WIDTH)
  ) u_mux (
    .latch_q(latch_q), .dir_q(dir_q), .func_q(func_q),
    .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .pin_sync(pin_sync),
    .pin_out(pin_out), .pin_oe(pin_oe), .rd_view(rd_view)
  );

  assign lcd_din = pin_sync;

  // Registered read: only the data address returns anything
  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_re)
      bus_rdata <= (sel == SEL_DATA) ? rd_view : '0;
  end

endmodule

// File: rtl/gpio_lcd_port_chk.sv
module gpio_lcd_port_chk #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 32'h2C
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  lcd_doe,
  input logic [WIDTH-1:0]  lcd_dout,
  input logic [WIDTH-1:0]  latch_q,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  func_q
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W-1:0] A_FUNC = ADDR_W'(BASE_ADDR + 2);

  logic seen_rst = 1'b0;
  logic after_rst = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
    after_rst <= rst;
  end

  logic in_window;
  assign in_window = (bus_addr == A_DATA) || (bus_addr == A_DIR) || (bus_addr == A_FUNC);

  // R1: the cycle after reset the port drives nothing and the latch is all ones
  assert_reset_state_R1: assert property (@(posedge clk)
    disable iff (!seen_rst) (after_rst && !rst) |-> (pin_oe == '0 && pin_out == '1 && bus_rdata == '0));

  // R2: a data write lands in the latch
  assert_latch_write_R2: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (bus_we && bus_addr == A_DATA) |=> (latch_q == $past(bus_wdata)));

  // R4: LCD-owned lines follow the LCD controller
  assert_lcd_owns_R4: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    ((pin_oe & func_q) == (lcd_doe & func_q)) && ((pin_out & func_q) == (lcd_dout & func_q)));

  // R6: write-only registers read as zero
  assert_wo_read_zero_R6: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (bus_re && (bus_addr == A_DIR || bus_addr == A_FUNC)) |=> (bus_rdata == '0));

  // R7: writes outside the window leave all state alone
  assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (bus_we && !in_window) |=> ($stable(latch_q) && $stable(dir_q) && $stable(func_q)));

  // R8: read data holds without a read strobe
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    !bus_re |=> $stable(bus_rdata));

endmodule

bind gpio_lcd_port gpio_lcd_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .pin_out(pin_out), .lcd_doe(lcd_doe), .lcd_dout(lcd_dout),
  .latch_q(latch_q), .dir_q(dir_q), .func_q(func_q)
);

// File: tb/test_gpio_lcd_port.sv
`timescale 1ns/1ps
module test_gpio_lcd_port;

  localparam int W = 8;
  localparam logic [7:0] A_DATA = 8'h2C;
  localparam logic [7:0] A_DIR  = 8'h2D;
  localparam logic [7:0] A_FUNC = 8'h2E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [W-1:0] bus_rdata, pin_out, pin_oe, lcd_din;
  logic [W-1:0] pin_in = '0, lcd_dout = '0, lcd_doe = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_lcd_port i_gpio_lcd_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .lcd_din(lcd_din)
  );

  task automatic check(input string req, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "oe after reset", pin_oe, 8'h00);
    check("R1", "out after reset", pin_out, 8'hFF);
    check("R1", "rdata after reset", bus_rdata, 8'h00);
  endtask

  task automatic t_latch_and_dir();
    bus_write(A_DATA, 8'h5A);
    check("R2", "oe unchanged by data write", pin_oe, 8'h00);
    check("R2", "latch loaded while input", pin_out, 8'h5A);
    bus_write(A_DIR, 8'hFF);
    check("R3", "oe all outputs", pin_oe, 8'hFF);
    check("R3", "out drives latch", pin_out, 8'h5A);
  endtask

  task automatic t_mixed_read();
    logic [W-1:0] d;
    bus_write(A_DIR, 8'h0F);
    check("R3", "oe per bit", pin_oe, 8'h0F);
    pin_in = 8'hA5;
    settle();
    bus_read(A_DATA, d);
    check("R5", "mixed read", d, 8'hAA);
    check("R9", "lcd_din synced pins", lcd_din, 8'hA5);
  endtask

  task automatic t_lcd_mux();
    logic [W-1:0] d;
    lcd_dout = 8'h3C; lcd_doe = 8'h90;
    bus_write(A_FUNC, 8'hF0);
    check("R4", "oe with lcd lines", pin_oe, 8'h9F);
    check("R4", "out with lcd lines", pin_out, 8'h3A);
    bus_write(A_DIR, 8'hFF);
    bus_write(A_DATA, 8'h00);
    check("R4", "dir ignored on lcd lines", pin_oe, 8'h9F);
    check("R4", "latch ignored on lcd lines", pin_out, 8'h30);
    bus_read(A_DATA, d);
    check("R5", "read with lcd lines", d, 8'hA0);
    lcd_doe = 8'h60; lcd_dout = 8'hC3;
    @(negedge clk);
    check("R4", "oe follows lcd_doe", pin_oe, 8'h6F);
    check("R4", "out follows lcd_dout", pin_out, 8'hC0);
  endtask

  task automatic t_write_only();
    logic [W-1:0] d;
    bus_read(A_DIR, d);
    check("R6", "dir reads zero", d, 8'h00);
    bus_read(A_FUNC, d);
    check("R6", "func reads zero", d, 8'h00);
    check("R6", "no side effect oe", pin_oe, 8'h6F);
    check("R6", "no side effect out", pin_out, 8'hC0);
  endtask

  task automatic t_unmapped();
    logic [W-1:0] d;
    bus_write(8'h2B, 8'h00);
    bus_write(8'h2F, 8'hFF);
    check("R7", "oe after stray writes", pin_oe, 8'h6F);
    check("R7", "out after stray writes", pin_out, 8'hC0);
    bus_read(8'h2F, d);
    check("R7", "stray read zero", d, 8'h00);
  endtask

  task automatic t_sync_and_hold();
    logic [W-1:0] d;
    bus_write(A_FUNC, 8'h00);
    bus_write(A_DIR, 8'h00);
    pin_in = 8'h11;
    settle();
    bus_read(A_DATA, d);
    check("R5", "input read", d, 8'h11);
    @(negedge clk);
    pin_in = 8'h77; bus_addr = A_DATA; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check("R9", "stale level at first edge", bus_rdata, 8'h11);
    settle();
    check("R8", "rdata holds without read", bus_rdata, 8'h11);
    bus_read(A_DATA, d);
    check("R9", "fresh level after sync", d, 8'h77);
    // same-edge write and read returns old latch value
    bus_write(A_DIR, 8'hFF);
    @(negedge clk);
    bus_addr = A_DATA; bus_wdata = 8'h42; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    check("R8", "read sees pre-write state", bus_rdata, 8'h00);
    check("R2", "write at same edge landed", pin_out, 8'h42);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latch_and_dir();
        t_mixed_read();
        t_lcd_mux();
        t_write_only();
        t_unmapped();
        t_sync_and_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule